// File: doc/BRIEF.md
# Bit Clock Recovery Loop

This block rebuilds a bit clock from a demodulated serial bit stream, so that a host can latch received bits with a clean clock instead of sampling the raw line itself. A programmable divider turns the system clock into a sample tick. Each bit period is sixteen ticks long. A phase counter walks through that period, and the recovered clock is low in the first half of the bit and high in the second half. Its falling edge therefore sits on the data transitions and its rising edge falls mid-bit, where the retimed data is steady.

While it is acquiring, the loop realigns its phase counter on every transition of either polarity. Once enough transitions in a row have landed near the expected bit boundary, it declares lock and switches to a gentler mode. In that mode only rising data edges steer it, one sample at a time. A small saturating integrator also stretches or shortens the bit period by one sample, so that a steady rate offset gets absorbed. The loop gives lock up in two cases: when rising edges keep landing far from the boundary, and when the line stays at one value for too long. While out of lock it holds both outputs low. A carrier-present input masks the data to zero when no signal is detected.

Top module: `clk_recovery_dpll`

## Requirements
- R1: While the synchronous active-low reset is asserted, `in_lock`, `rec_clk` and `rec_data` are all 0, and the loop restarts unlocked with its integrator and counters cleared.
- R2: Whenever `in_lock` is 0, `rec_clk` and `rec_data` are both 0.
- R3: While unlocked, transitions of both polarities are used. Lock is declared on the fourth consecutive transition that lands inside the window, so a stream with a steady bit rate locks within at most five transitions.
- R4: While locked, a bit spans sample positions 0 to P-1, where P is the current period (nominally 16). `rec_clk` is low for positions 0 to 7 and high from position 8 to P-1, so it falls at the bit boundary. `rec_data` takes the masked input sampled at position 4, so it holds steady across each rising edge of `rec_clk`.
- R5: While locked, only rising data edges adjust the phase and the integrator. Falling edges move nothing and do not count as out-of-window events.
- R6: The phase error of an edge is its position p when p < 8, and p - P otherwise. An edge lies inside the window when the error is between -4 and +4 samples. While unlocked, every transition restarts the phase at that edge, and an edge outside the window clears the count of transitions that were inside it.
- R7: While locked, two consecutive rising edges outside the window drop lock. A rising edge inside the window between them clears the miss count. An edge outside the window causes no phase correction.
- R8: When 33 consecutive bit periods end with no data transition, lock is dropped. Any transition restarts this count.
- R9: An in-window rising edge that arrives late (positive error) holds the phase for one tick and raises a saturating integrator (range -3 to +3). An early edge advances the phase by two ticks and lowers the integrator. The period is 17 when the integrator is at +2 or more, 15 at -2 or less, and 16 otherwise. Losing lock clears the integrator.
- R10: When `carrier_ok` is 0, the data input is treated as 0.
- R11: A sample tick occurs once every `baud_div`+1 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_div | input | DIVW | Clocks per sample tick, minus one |
| rx_bit | input | 1 | Demodulated data bit |
| carrier_ok | input | 1 | Carrier detected; when 0 the data is taken as 0 |
| rec_clk | output | 1 | Recovered bit clock |
| rec_data | output | 1 | Retimed data, stable at rising edge of rec_clk |
| in_lock | output | 1 | Loop is locked |

## Verification
The window boundary is tested with streams whose bits run four samples long, four samples short and five samples long. A window that is off by one would either lock on the five-sample offset or never lock on the four-sample one. A pulse train is sent whose falling edges land far outside the window. A loop that still steered on falling edges while locked would count misses and drop lock. A stream that runs one sample slow per bit has to stay locked, which only an integrator that really stretches the period can do. A purely first-order loop drifts out of the window on it. The bench also holds the line steady for 31 bit periods and then for 37. A run-length limit that is off by many periods, or never fires at all, gets caught on one side or the other.

// File: rtl/clk_recovery_dpll.sv
module clk_recovery_dpll #(
  parameter int OSR        = 16,
  parameter int WIN        = 4,
  parameter int LOCK_EDGES = 4,
  parameter int MISS_MAX   = 2,
  parameter int RUN_MAX    = 32,
  parameter int INT_MAX    = 3,
  parameter int INT_THR    = 2,
  parameter int DIVW       = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] baud_div,
  input  logic            rx_bit,
  input  logic            carrier_ok,
  output logic            rec_clk,
  output logic            rec_data,
  output logic            in_lock
);

  localparam int HALF = OSR / 2;
  localparam int DPT  = OSR / 4;
  localparam int PW   = $clog2(OSR + 2);
  localparam int PW1  = PW + 1;
  localparam int EW   = PW + 1;
  localparam int IW   = $clog2(INT_MAX + 1) + 1;
  localparam int CW   = $clog2(LOCK_EDGES + 1);
  localparam int MW   = $clog2(MISS_MAX + 1);
  localparam int RW   = $clog2(RUN_MAX + 1);

  localparam logic signed [IW-1:0] I_HI  = IW'(INT_MAX);
  localparam logic signed [IW-1:0] I_LO  = -IW'(INT_MAX);
  localparam logic signed [IW-1:0] T_HI  = IW'(INT_THR);
  localparam logic signed [IW-1:0] T_LO  = -IW'(INT_THR);
  localparam logic signed [EW-1:0] W_HI  = EW'(WIN);
  localparam logic signed [EW-1:0] W_LO  = -EW'(WIN);

  logic [DIVW-1:0]        div_q;
  logic [PW-1:0]          ph_q, ph_d, period;
  logic signed [IW-1:0]   int_q, int_d;
  logic [CW-1:0]          hit_q, hit_d;
  logic [MW-1:0]          miss_q, miss_d;
  logic [RW-1:0]          run_q, run_d;
  logic                   lock_q, lock_d, prev_q, data_q, drop;
  logic                   tick, samp, edge_w, rise_w, inwin, steer, wrap;
  logic signed [EW-1:0]   ph_s, per_s, perr;
  logic [1:0]             step;
  logic [PW1-1:0]         ph_sum;

  assign tick   = (div_q == '0);
  assign samp   = rx_bit & carrier_ok;
  assign edge_w = tick & (samp ^ prev_q);
  assign rise_w = edge_w & samp;

  assign period = PW'(OSR) + PW'(int_q >= T_HI) - PW'(int_q <= T_LO);
  assign ph_s   = $signed({1'b0, ph_q});
  assign per_s  = $signed({1'b0, period});
  assign perr   = (ph_q < PW'(HALF)) ? ph_s : ph_s - per_s;
  assign inwin  = (perr <= W_HI) && (perr >= W_LO);

  assign steer  = lock_q & rise_w & inwin;
  assign step   = !steer ? 2'd1 : (perr > 0) ? 2'd0 : (perr < 0) ? 2'd2 : 2'd1;
  assign ph_sum = {1'b0, ph_q} + PW1'(step);
  assign wrap   = (ph_sum >= {1'b0, period});

  always_comb begin
    ph_d   = ph_q;
    int_d  = int_q;
    hit_d  = hit_q;
    miss_d = miss_q;
    run_d  = run_q;
    lock_d = lock_q;
    drop   = 1'b0;
    if (tick) begin
      ph_d = wrap ? PW'(ph_sum - {1'b0, period}) : PW'(ph_sum);

      if (edge_w)
        run_d = '0;
      else if (wrap) begin
        if (run_q == RW'(RUN_MAX)) drop = 1'b1;
        else                       run_d = run_q + RW'(1);
      end

      if (!lock_q) begin
        if (edge_w) begin
          ph_d = PW'(1);
          if (!inwin)
            hit_d = '0;
          else if (hit_q == CW'(LOCK_EDGES - 1)) begin
            lock_d = 1'b1;
            hit_d  = '0;
            miss_d = '0;
          end else
            hit_d = hit_q + CW'(1);
        end
      end else if (rise_w) begin
        if (inwin) begin
          miss_d = '0;
          if (perr > 0 && int_q < I_HI)      int_d = int_q + IW'(1);
          else if (perr < 0 && int_q > I_LO) int_d = int_q - IW'(1);
        end else if (miss_q == MW'(MISS_MAX - 1))
          drop = 1'b1;
        else
          miss_d = miss_q + MW'(1);
      end
    end
    if (drop) begin
      lock_d = 1'b0;
      int_d  = '0;
      hit_d  = '0;
      miss_d = '0;
      run_d  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      ph_q   <= '0;
      int_q  <= '0;
      hit_q  <= '0;
      miss_q <= '0;
      run_q  <= '0;
      lock_q <= 1'b0;
      prev_q <= 1'b0;
      data_q <= 1'b0;
    end else begin
      div_q  <= tick ? baud_div : div_q - DIVW'(1);
      ph_q   <= ph_d;
      int_q  <= int_d;
      hit_q  <= hit_d;
      miss_q <= miss_d;
      run_q  <= run_d;
      lock_q <= lock_d;
      if (tick) prev_q <= samp;
      if (tick && ph_q == PW'(DPT)) data_q <= samp;
    end
  end

  assign in_lock  = lock_q;
  assign rec_clk  = lock_q & (ph_q >= PW'(HALF));
  assign rec_data = lock_q & data_q;

endmodule

// File: rtl/clk_recovery_dpll_chk.sv
module clk_recovery_dpll_chk #(
  parameter int IW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_lock,
  input logic                 rec_clk,
  input logic                 rec_data,
  input logic                 edge_w,
  input logic                 samp,
  input logic signed [IW-1:0] int_q
);

  p_idle_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_lock |-> (!rec_clk && !rec_data));

  p_lock_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_lock) |-> $past(edge_w));

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_clk && $past(rec_clk)) |-> $stable(rec_data));

  p_fall_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lock && edge_w && !samp) |=> $stable(int_q));

  p_unlock_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_lock) |-> (int_q == '0));

endmodule

bind clk_recovery_dpll clk_recovery_dpll_chk #(.IW(IW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_lock  (in_lock),
  .rec_clk  (rec_clk),
  .rec_data (rec_data),
  .edge_w   (edge_w),
  .samp     (samp),
  .int_q    (int_q)
);

// File: tb/test_clk_recovery_dpll.sv
`timescale 1ns/1ps
module test_clk_recovery_dpll;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_div = '0;
  logic        din = 1'b0;
  logic        carrier = 1'b1;
  logic        rec_clk, rec_data, in_lock;

  int n_cmp = 0, n_bad = 0;
  int n_rise = 0, n_fall = 0;
  bit done = 0, mon_en = 0, lk_prev = 0, rc_prev = 0, cur = 0;

  // reference model state
  int m_div = 0, m_ph = 0, m_int = 0, m_hit = 0, m_miss = 0, m_run = 0;
  bit m_lock = 0, m_rd = 0, m_prev = 0;

  always #2.5 clk = ~clk;

  clk_recovery_dpll i_clk_recovery_dpll (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .rx_bit(din),
    .carrier_ok(carrier), .rec_clk(rec_clk), .rec_data(rec_data), .in_lock(in_lock)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_ph = 0; m_int = 0; m_hit = 0; m_miss = 0; m_run = 0;
      m_lock = 0; m_rd = 0; m_prev = 0;
    end else if (m_div != 0) begin
      m_div = m_div - 1;
    end else begin
      bit s, ed, up, ok, wr, lost;
      int per, err, adv, nph;
      s    = din && carrier;
      per  = 16 + ((m_int >= 2) ? 1 : 0) - ((m_int <= -2) ? 1 : 0);
      err  = (m_ph < 8) ? m_ph : m_ph - per;
      ok   = (err >= -4) && (err <= 4);
      ed   = (s != m_prev);
      up   = ed && s;
      adv  = 1;
      if (m_lock && up && ok) adv = (err > 0) ? 0 : ((err < 0) ? 2 : 1);
      nph  = m_ph + adv;
      wr   = (nph >= per);
      if (wr) nph = nph - per;
      lost = 0;
      if (m_ph == 4) m_rd = s;
      if (!m_lock) begin
        if (ed) begin
          nph = 1;
          if (ok) begin
            m_hit++;
            if (m_hit == 4) begin m_lock = 1; m_hit = 0; m_miss = 0; end
          end else m_hit = 0;
        end
      end else if (up) begin
        if (ok) begin
          m_miss = 0;
          if (err > 0 && m_int < 3) m_int++;
          else if (err < 0 && m_int > -3) m_int--;
        end else begin
          m_miss++;
          if (m_miss == 2) lost = 1;
        end
      end
      if (ed) m_run = 0;
      else if (wr) begin
        if (m_run == 32) lost = 1; else m_run++;
      end
      if (lost) begin m_lock = 0; m_int = 0; m_hit = 0; m_miss = 0; m_run = 0; end
      m_ph = nph; m_prev = s; m_div = int'(baud_div);
    end
  end

  always @(negedge clk) begin
    check("R3 in_lock vs model", int'(in_lock), int'(m_lock));
    check("R4 rec_clk vs model", int'(rec_clk), int'(m_lock && m_ph >= 8));
    check("R4 rec_data vs model", int'(rec_data), int'(m_lock && m_rd));
    if (in_lock && !lk_prev) n_rise++;
    if (!in_lock && lk_prev) n_fall++;
    if (mon_en && rec_clk && !rc_prev) check("R4 rec_data at rec_clk rise", int'(rec_data), int'(din));
    lk_prev = in_lock;
    rc_prev = rec_clk;
  end

  task automatic send(input bit v, input int len);
    din = v;
    repeat (len) @(negedge clk);
  endtask

  task automatic flips(input int n, input int len);
    for (int i = 0; i < n; i++) begin
      cur = ~cur;
      send(cur, len);
    end
  endtask

  task automatic report;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual expired expected completion");
      report();
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    check("R1 in_lock in reset", int'(in_lock), 0);
    check("R1 rec_clk in reset", int'(rec_clk), 0);
    check("R1 rec_data in reset", int'(rec_data), 0);
    rst_n = 1'b1;

    flips(2, 16);
    check("R2 unlocked in_lock", int'(in_lock), 0);
    check("R2 unlocked rec_clk", int'(rec_clk), 0);
    flips(3, 16);
    check("R3 locked after five transitions", int'(in_lock), 1);

    mon_en = 1;
    begin
      int run = 0;
      for (int i = 0; i < 200; i++) begin
        if (run >= 6 || $urandom_range(0, 1) == 1) begin cur = ~cur; run = 0; end
        else run++;
        send(cur, 16);
      end
    end
    mon_en = 0;
    check("R4 still locked on random data", int'(in_lock), 1);

    if (cur) flips(1, 16);
    n_fall = 0;
    for (int i = 0; i < 8; i++) begin
      cur = 1; send(1, 22);
      cur = 0; send(0, 10);
    end
    check("R5 falling edges off-window no unlock", n_fall, 0);
    check("R5 locked after pulse train", int'(in_lock), 1);
    flips(4, 16);

    send(cur, 30 * 16);
    check("R8 locked after 31 quiet periods", int'(in_lock), 1);
    send(cur, 6 * 16);
    check("R8 unlocked after 37 quiet periods", int'(in_lock), 0);

    flips(6, 16);
    check("R3 relock", int'(in_lock), 1);
    n_fall = 0;
    cur = ~cur; send(cur, 24);
    flips(6, 16);
    check("R7 lock dropped on phase jump", int'(n_fall >= 1), 1);
    send(cur, 40 * 16);

    n_rise = 0;
    flips(12, 21);
    check("R6 five-sample offset never locks", n_rise, 0);
    flips(10, 20);
    check("R6 four-sample late offset locks", int'(n_rise >= 1), 1);
    send(cur, 40 * 16);
    n_rise = 0;
    flips(10, 12);
    check("R6 four-sample early offset locks", int'(n_rise >= 1), 1);
    send(cur, 40 * 16);

    flips(6, 17);
    n_fall = 0;
    flips(40, 17);
    check("R9 slow stream stays locked", n_fall, 0);
    check("R9 locked at end of slow stream", int'(in_lock), 1);
    send(cur, 40 * 16);

    flips(6, 16);
    if (cur) flips(1, 16);
    check("R10 locked before carrier loss", int'(in_lock), 1);
    carrier = 1'b0;
    send(1, 32);
    check("R10 masked data reads 0", int'(rec_data), 0);
    check("R10 no edge from masked data", int'(in_lock), 1);
    for (int i = 0; i < 40; i++) send(i[0], 16);
    check("R10 toggling without carrier drops lock", int'(in_lock), 0);
    carrier = 1'b1;
    cur = 0; send(0, 16);

    baud_div = 16'd1;
    n_rise = 0;
    flips(8, 32);
    check("R11 lock at halved tick rate", int'(in_lock), 1);
    check("R11 single lock event", n_rise, 1);

    report();
  end

endmodule